// File: doc/BRIEF.md
# Strap-Addressed I2C Control Register Target

This block is the serial control port of a multi-output clock device. It sits on a two-wire I2C bus as a target. It holds seventeen byte-wide control registers and presents their contents as parallel outputs to the clock logic. A register pointer byte follows the device address. A transfer writes exactly one data byte, or it reads exactly one byte after a repeated START. Register 0 is a broadcast location: one write to it sets all fifteen per-output registers together. Registers 1 to 15 each drive one output. Register 16 drives the frequency-margin setting.

The 7-bit bus address comes from two three-level strap inputs, which arrive already decoded, and a fixed nine-entry table. Both bus lines are brought into the system clock through a short synchronizer. All protocol decisions are made in the system clock domain. The target never drives SDA high. It only asserts a pull-low enable, and it changes that enable only while SCL is low.

Top module: `i2c_clkgen_regs`

## Requirements
- R1: The 7-bit address is a lookup on the strap pair (strap_hi, strap_lo), where each code is 00 = tied low, 01 = tied high, 10 = open, and 11 = open. The table is: open/high 0x62, open/low 0x64, open/open 0x68, low/high 0x70, low/low 0x69, low/open 0x6C, high/high 0x74, high/low 0x72, high/open 0x71. An address byte whose upper seven bits differ from this address is NACKed, and the rest of that transfer has no effect.
- R2: A matching address byte is ACKed by pulling SDA low during the 9th SCL clock. The register byte and the single write data byte are also ACKed.
- R3: A write of address+W, register n (1 to 16), data d, then STOP leaves register n equal to d. Register n drives out_cfg[(n-1)*8 +: 8] for n up to 15, and drives margin_cfg for n = 16.
- R4: A completed write to register 0 sets register 0 and all fifteen per-output registers to the data byte. margin_cfg is left unchanged. A later read of register 0 returns that byte.
- R5: A written byte takes effect only when STOP follows it. If a START arrives before the STOP, the pending byte is discarded.
- R6: A data byte after the first one in a write is NACKed and stores nothing.
- R7: A write to a register number from 0x11 to 0xFF is ACKed but changes no register. A read of such a number returns 0x00.
- R8: The sequence address+W, register n, repeated START, address+R returns register n, MSB first, in the following eight clocks.
- R9: After the single read byte, the target releases SDA whether or not the master ACKs. Any further byte therefore reads as 0xFF.
- R10: After synchronous reset, all registers are 0x00 and SDA is released. SDA stays released while no transfer is active.
- R11: The pull-low enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | Open-drain enable; 1 pulls SDA low |
| strap_hi | input | 2 | Decoded level of the high address strap |
| strap_lo | input | 2 | Decoded level of the low address strap |
| out_cfg | output | 120 | Per-output registers 1..15, register n in bits (n-1)*8 +: 8 |
| margin_cfg | output | 8 | Frequency-margin register (16) |

## Verification
The register file can only change when a STOP arrives. A wrong commit condition or a wrong broadcast fan-out therefore appears on out_cfg or margin_cfg within a few system clocks of that STOP. The bench compares every output register against its model on every clock between transfers. A wrong protocol state, such as a stale pointer, a missed NACK after the data byte, or a drive that continues after the read byte, appears at the ACK or data bit of the same byte. The bench samples SDA in the middle of each SCL high phase, so such a fault shows within one bit time.

// File: rtl/i2c_cg_pkg.sv
package i2c_cg_pkg;
    localparam int BYTE_W  = 8;
    localparam int NUM_OUT = 15;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_REG, ST_WDATA, ST_TX, ST_DONE
    } xfer_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] idx;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // Strap code: 00 low, 01 high, 10/11 open.
    function automatic logic [6:0] strap_addr(input logic [1:0] hi, input logic [1:0] lo);
        logic [1:0] h;
        logic [1:0] l;
        logic [6:0] a;
        h = (hi == 2'b11) ? 2'b10 : hi;
        l = (lo == 2'b11) ? 2'b10 : lo;
        case ({h, l})
            4'b1001: a = 7'h62;
            4'b1000: a = 7'h64;
            4'b1010: a = 7'h68;
            4'b0001: a = 7'h70;
            4'b0000: a = 7'h69;
            4'b0010: a = 7'h6C;
            4'b0101: a = 7'h74;
            4'b0100: a = 7'h72;
            4'b0110: a = 7'h71;
            default: a = 7'h68;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/i2c_cg_linesync.sv
module i2c_cg_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_cg_proto.sv
module i2c_cg_proto
    import i2c_cg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_idx,
    output wr_req_t           wr,
    output logic              sda_pull
);
    xfer_e             state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txq;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] pend_data;
    logic              pend;
    logic              accept;
    logic              pull;
    logic              addr_hit;

    assign addr_hit = (shreg[7:1] == dev_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE; bitcnt <= '0; shreg <= '0; txq <= '0; ptr <= '0;
            pend_data <= '0; pend <= 1'b0; accept <= 1'b0; pull <= 1'b0;
        end else if (start_det || stop_det) begin
            state  <= start_det ? ST_ADDR : ST_IDLE;
            bitcnt <= '0;
            pull   <= 1'b0;
            pend   <= 1'b0;
            accept <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (scl_rise) begin
                if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
                if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
                if (bitcnt == 4'd8) begin
                    // acknowledge slot opens
                    case (state)
                        ST_ADDR:  begin accept <= addr_hit; pull <= addr_hit; end
                        ST_REG:   begin accept <= 1'b1; pull <= 1'b1; ptr <= shreg; end
                        ST_WDATA: begin accept <= 1'b1; pull <= 1'b1; pend <= 1'b1; pend_data <= shreg; end
                        default:  begin accept <= 1'b0; pull <= 1'b0; end
                    endcase
                end else if (bitcnt == 4'd9) begin
                    // acknowledge slot closes: advance
                    bitcnt <= '0;
                    pull   <= 1'b0;
                    case (state)
                        ST_ADDR: begin
                            if (!accept) state <= ST_DONE;
                            else if (shreg[0]) begin
                                state <= ST_TX;
                                txq   <= rd_data;
                                pull  <= ~rd_data[7];
                            end else state <= ST_REG;
                        end
                        ST_REG:  state <= ST_WDATA;
                        default: state <= ST_DONE;
                    endcase
                end else if (state == ST_TX && bitcnt != 4'd0) begin
                    pull <= ~txq[3'(7 - bitcnt)];
                end
            end
        end
    end

    assign rd_idx   = ptr;
    assign sda_pull = pull;
    assign wr.valid = stop_det & pend;
    assign wr.idx   = ptr;
    assign wr.data  = pend_data;

    // R11: the drive never moves while SCL is held high
    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull));
    // R10: nothing driven outside a transfer
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_pull);
    // R6 / R9: after the single data byte the target stays silent
    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |-> !sda_pull);
endmodule

// File: rtl/i2c_cg_regfile.sv
module i2c_cg_regfile
    import i2c_cg_pkg::*;
#(
    parameter int N_OUT = NUM_OUT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wr_req_t                 wr,
    input  logic [BYTE_W-1:0]       rd_idx,
    output logic [BYTE_W-1:0]       rd_data,
    output logic [N_OUT*BYTE_W-1:0] out_cfg,
    output logic [BYTE_W-1:0]       margin_cfg
);
    localparam int N_REG = N_OUT + 2;
    localparam logic [BYTE_W-1:0] MARGIN_IDX = BYTE_W'(N_OUT + 1);

    logic [BYTE_W-1:0] regs [N_REG];
    logic              bcast;

    assign bcast = wr.valid && (wr.idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_REG; i++) regs[i] <= '0;
        end else if (wr.valid) begin
            for (int i = 0; i < N_REG; i++) begin
                if (wr.idx == BYTE_W'(i) || (bcast && i >= 1 && i <= N_OUT))
                    regs[i] <= wr.data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_REG; i++)
            if (rd_idx == BYTE_W'(i)) rd_data = regs[i];
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        assign out_cfg[g*BYTE_W +: BYTE_W] = regs[g+1];
    end
    assign margin_cfg = regs[N_OUT+1];

    // R4: broadcast reaches every per-output register
    assert_bcast_fanout_R4: assert property (@(posedge clk) disable iff (rst)
        $past(bcast) |-> (out_cfg == {N_OUT{$past(wr.data)}}));
    // R7: reserved indices leave all outputs untouched
    assert_rsvd_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        $past(wr.valid && wr.idx > MARGIN_IDX) |-> ($stable(out_cfg) && $stable(margin_cfg)));
endmodule

// File: rtl/i2c_clkgen_regs.sv
module i2c_clkgen_regs
    import i2c_cg_pkg::*;
#(
    parameter int N_OUT       = NUM_OUT,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_in,
    input  logic                    sda_in,
    output logic                    sda_pull,
    input  logic [1:0]              strap_hi,
    input  logic [1:0]              strap_lo,
    output logic [N_OUT*BYTE_W-1:0] out_cfg,
    output logic [BYTE_W-1:0]       margin_cfg
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rd_idx;
    logic [BYTE_W-1:0] rd_data;
    wr_req_t           wr;
    logic [6:0]        dev_addr;

    assign dev_addr = strap_addr(strap_hi, strap_lo);

    i2c_cg_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_cg_proto u_proto (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .dev_addr(dev_addr), .rd_data(rd_data), .rd_idx(rd_idx),
        .wr(wr), .sda_pull(sda_pull)
    );

    i2c_cg_regfile #(.N_OUT(N_OUT)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .rd_idx(rd_idx), .rd_data(rd_data),
        .out_cfg(out_cfg), .margin_cfg(margin_cfg)
    );
endmodule

// File: tb/i2c_clkgen_regs_test.sv
`timescale 1ns/1ps
module i2c_clkgen_regs_test;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic [1:0] s_hi = 2'b00;
    logic [1:0] s_lo = 2'b00;
    logic sda_pull;
    logic sda_line;
    logic [119:0] out_cfg;
    logic [7:0] margin_cfg;

    int checks = 0;
    int errors = 0;
    int exp_reg [17];
    bit settled = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = ~(m_low | sda_pull);

    i2c_clkgen_regs uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull),
        .strap_hi(s_hi), .strap_lo(s_lo), .out_cfg(out_cfg), .margin_cfg(margin_cfg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Reference model compared on every clock between transfers (R3, R4, R10)
    always @(negedge clk) begin
        if (settled && !rst) begin
            for (int i = 1; i <= 15; i++)
                chk(out_cfg[(i-1)*8 +: 8] == exp_reg[i][7:0], "R3 per-output register",
                    int'(out_cfg[(i-1)*8 +: 8]), exp_reg[i]);
            chk(margin_cfg == exp_reg[16][7:0], "R3 margin register", int'(margin_cfg), exp_reg[16]);
            chk(!sda_pull, "R10 released between transfers", int'(sda_pull), 0);
        end
    end

    function automatic logic [6:0] ref_addr(input int h, input int l);
        int hh = (h == 3) ? 2 : h;
        int ll = (l == 3) ? 2 : l;
        if (hh == 2 && ll == 1) return 7'h62;
        if (hh == 2 && ll == 0) return 7'h64;
        if (hh == 2 && ll == 2) return 7'h68;
        if (hh == 0 && ll == 1) return 7'h70;
        if (hh == 0 && ll == 0) return 7'h69;
        if (hh == 0 && ll == 2) return 7'h6C;
        if (hh == 1 && ll == 1) return 7'h74;
        if (hh == 1 && ll == 0) return 7'h72;
        return 7'h71;
    endfunction

    task automatic model_write(input int r, input int d);
        if (r == 0) for (int i = 0; i <= 15; i++) exp_reg[i] = d;
        else if (r <= 16) exp_reg[r] = d;
    endtask

    task automatic wait_q(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        settled = 1'b0;
        m_low = 1'b0; wait_q(); scl = 1'b1; wait_q(); m_low = 1'b1; wait_q(); scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wait_q(); scl = 1'b1; wait_q(); m_low = 1'b0; wait_q(); wait_q();
    endtask

    task automatic send_bit(input bit b, output bit s);
        m_low = !b; wait_q(); scl = 1'b1;
        repeat (Q/2) @(negedge clk);
        s = sda_line;
        repeat (Q/2) @(negedge clk);
        scl = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) send_bit(v[i], s);
        send_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin send_bit(1'b1, s); v[i] = s; end
        send_bit(!master_ack, s);
    endtask

    task automatic write_txn(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                             output bit k0, output bit k1, output bit k2);
        bus_start();
        send_byte({a, 1'b0}, k0);
        send_byte(r, k1);
        send_byte(d, k2);
        bus_stop();
    endtask

    task automatic read_txn(input logic [6:0] a, input logic [7:0] r, output logic [7:0] d,
                            output bit k0, output bit k1, output bit k2);
        bus_start();
        send_byte({a, 1'b0}, k0);
        send_byte(r, k1);
        bus_start();
        send_byte({a, 1'b1}, k2);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit k0, k1, k2, k3;
        logic [7:0] d;
        for (int i = 0; i < 17; i++) exp_reg[i] = 0;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(out_cfg == '0, "R10 reset per-output", int'(out_cfg[31:0]), 0);
        chk(margin_cfg == 8'h00, "R10 reset margin", int'(margin_cfg), 0);
        chk(!sda_pull, "R10 reset SDA released", int'(sda_pull), 0);
        settled = 1'b1;

        // straps low/low -> 0x69; write and read back (R2, R3, R8)
        s_hi = 2'd0; s_lo = 2'd0; wait_q();
        write_txn(7'h69, 8'h05, 8'hA5, k0, k1, k2);
        chk(k0 && k1 && k2, "R2 three ACKs on write", {k0, k1, k2}, 7);
        model_write(5, 8'hA5); settled = 1'b1; wait_q();
        read_txn(7'h69, 8'h05, d, k0, k1, k2);
        chk(k2, "R2 ACK on address+R", k2, 1);
        chk(d == 8'hA5, "R8 random read", d, 8'hA5);
        settled = 1'b1;

        // R1: wrong address is NACKed and changes nothing
        write_txn(7'h62, 8'h05, 8'h3C, k0, k1, k2);
        chk(!k0, "R1 NACK on foreign address", k0, 0);
        settled = 1'b1; wait_q();

        // R1: restrap to high/open -> 0x71
        s_hi = 2'd1; s_lo = 2'd2; wait_q();
        write_txn(7'h69, 8'h10, 8'h99, k0, k1, k2);
        chk(!k0, "R1 old address NACKed after restrap", k0, 0);
        settled = 1'b1; wait_q();
        write_txn(7'h71, 8'h10, 8'h3C, k0, k1, k2);
        chk(k0, "R1 new address ACKed", k0, 1);
        model_write(16, 8'h3C); settled = 1'b1; wait_q();

        // R4: broadcast
        write_txn(7'h71, 8'h00, 8'h5A, k0, k1, k2);
        model_write(0, 8'h5A); settled = 1'b1; wait_q();
        read_txn(7'h71, 8'h00, d, k0, k1, k2);
        chk(d == 8'h5A, "R4 broadcast register readback", d, 8'h5A);
        chk(margin_cfg == 8'h3C, "R4 margin untouched by broadcast", margin_cfg, 8'h3C);
        settled = 1'b1;

        // R6: extra data byte NACKed and not stored
        bus_start();
        send_byte({7'h71, 1'b0}, k0);
        send_byte(8'h07, k1);
        send_byte(8'h11, k2);
        send_byte(8'h22, k3);
        bus_stop();
        chk(k2, "R6 first data byte ACKed", k2, 1);
        chk(!k3, "R6 second data byte NACKed", k3, 0);
        model_write(7, 8'h11); settled = 1'b1; wait_q();

        // R5: START before STOP discards the pending byte
        bus_start();
        send_byte({7'h71, 1'b0}, k0);
        send_byte(8'h03, k1);
        send_byte(8'h77, k2);
        write_txn(7'h71, 8'h04, 8'h44, k0, k1, k2);
        model_write(4, 8'h44); settled = 1'b1; wait_q();
        chk(out_cfg[2*8 +: 8] == 8'h5A, "R5 uncommitted write dropped", out_cfg[2*8 +: 8], 8'h5A);

        // R7: reserved write ignored, reserved read returns zero
        write_txn(7'h71, 8'h11, 8'hFF, k0, k1, k2);
        chk(k2, "R7 reserved data ACKed", k2, 1);
        settled = 1'b1; wait_q();
        read_txn(7'h71, 8'h20, d, k0, k1, k2);
        chk(d == 8'h00, "R7 reserved read", d, 0);
        settled = 1'b1;

        // R9: master ACKs, second byte must read as released
        bus_start();
        send_byte({7'h71, 1'b0}, k0);
        send_byte(8'h07, k1);
        bus_start();
        send_byte({7'h71, 1'b1}, k2);
        recv_byte(1'b1, d);
        chk(d == 8'h11, "R8 read before burst attempt", d, 8'h11);
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R9 no burst read", d, 8'hFF);
        bus_stop();
        settled = 1'b1;

        // R1: every strap combination, including code 11 as open
        for (int h = 0; h < 4; h++) begin
            for (int l = 0; l < 4; l++) begin
                logic [6:0] ea;
                if ((h == 3) != (l == 3)) continue;
                s_hi = 2'(h); s_lo = 2'(l); wait_q();
                ea = ref_addr(h, l);
                bus_start(); send_byte({ea, 1'b0}, k0); bus_stop();
                chk(k0, "R1 strap table ACK", k0, 1);
                bus_start(); send_byte({ea ^ 7'h01, 1'b0}, k0); bus_stop();
                chk(!k0, "R1 strap table NACK", k0, 0);
                settled = 1'b1;
            end
        end

        wait_q();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule